// File: doc/BRIEF.md
# Scheduled Sample Release Gate

This block sits between one transmit channel's sample FIFO and that channel's transmit chain. Each packet in the FIFO starts with two header words, a start time and a sample count, followed by the samples themselves as 32-bit I/Q words. The block keeps a running time register that advances once per downstream sample strobe. It holds the packet at the head of the FIFO until that register reaches the packet's start time. It then hands exactly the stated number of samples to the transmit chain, one per strobe.

Packets reach the FIFO in ascending time order, so only the head packet is ever compared. A head packet whose start time has already passed is drained and thrown away, and a sticky late flag records it. When a sample is due but the FIFO has run dry, a zero goes out instead and a sticky underrun flag is set. The output strobe never stops: whenever no real sample is due, the block sends zeros at the same rate, so the chain behind it always sees a constant rate. A start time of all ones asks for release on the next strobe, whatever the time register holds.

Top module: `sample_release_gate`

## Requirements
- R1: After reset, outValid, lateFlag, underrunFlag and fifoRead are 0 and timeNow is 0.
- R2: timeNow rises by exactly 1, modulo 2^32, after each cycle with sampleStrobe high. A cycle with timeLoad high instead loads timeLoadValue, and load wins over the strobe. In any other cycle timeNow holds.
- R3: A packet is read as a first word holding the 32-bit start time, then a second word whose low CNT_W bits hold the sample count, then the samples. fifoRead pops one word per cycle and is never high while fifoEmpty is high.
- R4: While the head packet's start time is ahead of timeNow, taken as a signed 32-bit difference, none of its samples is popped.
- R5: The first sample of a packet is released by the strobe whose cycle has timeNow equal to the start time.
- R6: A released packet gives exactly its count of samples, in FIFO order, one per strobe. The next strobe after the last of them outputs zero unless the following packet is due.
- R7: A start time of 32'hFFFF_FFFF is never late and is released on the first strobe after its header has been read.
- R8: A packet whose start time minus timeNow is negative as a signed 32-bit value, when examined at the head, is popped to its end at one word per cycle, produces no output sample, and sets lateFlag.
- R9: When a sample is due and the FIFO is empty, the strobe outputs zero and underrunFlag is set. The remaining count is kept, and the samples that arrive later are still released.
- R10: A strobe with no sample to release yields outValid high with outSample zero.
- R11: lateFlag and underrunFlag stay set until a cycle with lateClr or underrunClr, respectively, is high. That cycle clears the flag.
- R12: A packet with a count of zero is skipped without output and without setting lateFlag.
- R13: outValid is high in exactly the cycle after each cycle with sampleStrobe high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoData | input | 32 | Head word of the channel FIFO (show-ahead) |
| fifoEmpty | input | 1 | FIFO has no word |
| fifoRead | output | 1 | Pop the head word this cycle |
| sampleStrobe | input | 1 | Downstream requests one sample |
| timeLoad | input | 1 | Load the time register |
| timeLoadValue | input | 32 | Value for the time register load |
| timeNow | output | 32 | Current time register |
| outSample | output | 32 | I/Q sample to the transmit chain |
| outValid | output | 1 | outSample is valid this cycle |
| lateClr | input | 1 | Write-one-to-clear for lateFlag |
| lateFlag | output | 1 | Sticky late-packet flag |
| underrunClr | input | 1 | Write-one-to-clear for underrunFlag |
| underrunFlag | output | 1 | Sticky underrun flag |

## Verification
The main release path is swept over every combination of start-time lead (zero to three strobes ahead) and packet length (one to three samples). Each case shows whether the first sample lands on exactly the matching strobe and whether the packet ends with no extra sample or missing one. The late-packet comparison is tried with plain past times and with times that straddle the 32-bit wrap, in both directions. This separates a signed difference from an unsigned compare. Separate cases cover the all-ones start time, a starved FIFO partway through a packet, and a zero-length packet followed by a due one. Each of these singles out one branch of the sequencer.

// File: rtl/srel_pkg.sv
package srel_pkg;

  typedef enum logic [2:0] {
    ST_HDR  = 3'd0,
    ST_CNT  = 3'd1,
    ST_HOLD = 3'd2,
    ST_SEND = 3'd3,
    ST_DROP = 3'd4
  } relState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capTs;
    logic capCnt;
    logic decCnt;
    logic emit;
    logic setLate;
    logic setUnder;
  } relCtrl_t;

endpackage

// File: rtl/srel_datapath.sv
module srel_datapath
  import srel_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  relCtrl_t          ctrl,
  input  logic [WORD_W-1:0] fifoData,
  input  logic              sampleStrobe,
  input  logic              timeLoad,
  input  logic [WORD_W-1:0] timeLoadValue,
  input  logic              lateClr,
  input  logic              underrunClr,
  output logic [WORD_W-1:0] timeNow,
  output logic [WORD_W-1:0] outSample,
  output logic              outValid,
  output logic              lateFlag,
  output logic              underrunFlag,
  output logic              tsGo,
  output logic              tsLate,
  output logic              cntLast,
  output logic              hdrCntZero
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [WORD_W-1:0] tsReg;
  logic [CNT_W-1:0]  cntReg;
  logic [WORD_W-1:0] tsDiff;
  logic              tsImm;

  // time register: load beats strobe
  always_ff @(posedge clk) begin
    if (!rstN)             timeNow <= '0;
    else if (timeLoad)     timeNow <= timeLoadValue;
    else if (sampleStrobe) timeNow <= timeNow + 1'b1;
  end

  // header registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tsReg  <= '0;
      cntReg <= '0;
    end else begin
      if (ctrl.capTs)       tsReg  <= fifoData;
      if (ctrl.capCnt)      cntReg <= fifoData[CNT_W-1:0];
      else if (ctrl.decCnt) cntReg <= cntReg - 1'b1;
    end
  end

  // compare
  always_comb begin
    tsDiff     = tsReg - timeNow;
    tsImm      = &tsReg;
    tsGo       = tsImm || (tsDiff == '0);
    tsLate     = !tsImm && tsDiff[WORD_W-1];
    cntLast    = (cntReg == CNT_ONE);
    hdrCntZero = (fifoData[CNT_W-1:0] == '0);
  end

  // output stage: constant-rate, zero fill
  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outSample <= '0;
    end else begin
      outValid  <= sampleStrobe;
      outSample <= (sampleStrobe && ctrl.emit) ? fifoData : '0;
    end
  end

  // sticky flags, set wins over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lateFlag     <= 1'b0;
      underrunFlag <= 1'b0;
    end else begin
      lateFlag     <= ctrl.setLate  | (lateFlag & ~lateClr);
      underrunFlag <= ctrl.setUnder | (underrunFlag & ~underrunClr);
    end
  end

endmodule

// File: rtl/srel_ctrl.sv
module srel_ctrl
  import srel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     fifoEmpty,
  input  logic     sampleStrobe,
  input  logic     tsGo,
  input  logic     tsLate,
  input  logic     cntLast,
  input  logic     hdrCntZero,
  output relCtrl_t ctrl,
  output logic     fifoRead
);

  relState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_HDR;
    else       state <= stateNext;
  end

  always_comb begin
    ctrl      = '0;
    stateNext = state;
    unique case (state)
      ST_HDR: begin
        if (!fifoEmpty) begin
          ctrl.capTs = 1'b1;
          stateNext  = ST_CNT;
        end
      end
      ST_CNT: begin
        if (!fifoEmpty) begin
          ctrl.capCnt = 1'b1;
          stateNext   = hdrCntZero ? ST_HDR : ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (tsLate) begin
          ctrl.setLate = 1'b1;
          stateNext    = ST_DROP;
        end else if (tsGo && sampleStrobe) begin
          if (!fifoEmpty) begin
            ctrl.emit   = 1'b1;
            ctrl.decCnt = 1'b1;
            stateNext   = cntLast ? ST_HDR : ST_SEND;
          end else begin
            ctrl.setUnder = 1'b1;
            stateNext     = ST_SEND;
          end
        end
      end
      ST_SEND: begin
        if (sampleStrobe) begin
          if (!fifoEmpty) begin
            ctrl.emit   = 1'b1;
            ctrl.decCnt = 1'b1;
            if (cntLast) stateNext = ST_HDR;
          end else begin
            ctrl.setUnder = 1'b1;
          end
        end
      end
      ST_DROP: begin
        if (!fifoEmpty) begin
          ctrl.decCnt = 1'b1;
          if (cntLast) stateNext = ST_HDR;
        end
      end
      default: stateNext = ST_HDR;
    endcase
    fifoRead = ctrl.capTs | ctrl.capCnt | ctrl.decCnt;
  end

endmodule

// File: rtl/sample_release_gate.sv
module sample_release_gate
  import srel_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] fifoData,
  input  logic              fifoEmpty,
  output logic              fifoRead,
  input  logic              sampleStrobe,
  input  logic              timeLoad,
  input  logic [WORD_W-1:0] timeLoadValue,
  output logic [WORD_W-1:0] timeNow,
  output logic [WORD_W-1:0] outSample,
  output logic              outValid,
  input  logic              lateClr,
  output logic              lateFlag,
  input  logic              underrunClr,
  output logic              underrunFlag
);

  relCtrl_t ctrl;
  logic     tsGo, tsLate, cntLast, hdrCntZero;

  srel_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .fifoEmpty    (fifoEmpty),
    .sampleStrobe (sampleStrobe),
    .tsGo         (tsGo),
    .tsLate       (tsLate),
    .cntLast      (cntLast),
    .hdrCntZero   (hdrCntZero),
    .ctrl         (ctrl),
    .fifoRead     (fifoRead)
  );

  srel_datapath #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctrl          (ctrl),
    .fifoData      (fifoData),
    .sampleStrobe  (sampleStrobe),
    .timeLoad      (timeLoad),
    .timeLoadValue (timeLoadValue),
    .lateClr       (lateClr),
    .underrunClr   (underrunClr),
    .timeNow       (timeNow),
    .outSample     (outSample),
    .outValid      (outValid),
    .lateFlag      (lateFlag),
    .underrunFlag  (underrunFlag),
    .tsGo          (tsGo),
    .tsLate        (tsLate),
    .cntLast       (cntLast),
    .hdrCntZero    (hdrCntZero)
  );

endmodule

// File: rtl/srel_checker.sv
module srel_checker #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sampleStrobe,
  input logic              timeLoad,
  input logic [WORD_W-1:0] timeLoadValue,
  input logic [WORD_W-1:0] timeNow,
  input logic              outValid,
  input logic              fifoRead,
  input logic              fifoEmpty,
  input logic              lateFlag,
  input logic              lateClr,
  input logic              underrunFlag,
  input logic              underrunClr
);

  logic warm;
  always_ff @(posedge clk) begin
    if (!rstN) warm <= 1'b0;
    else       warm <= 1'b1;
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    fifoRead |-> !fifoEmpty); // R3
  AST_TIME_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && !timeLoad) |=> timeNow == $past(timeNow) + 1'b1); // R2
  AST_TIME_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    timeLoad |=> timeNow == $past(timeLoadValue)); // R2
  AST_TIME_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleStrobe && !timeLoad) |=> $stable(timeNow)); // R2
  AST_VALID_RATE: assert property (@(posedge clk) disable iff (!rstN)
    warm |=> outValid == $past(sampleStrobe)); // R13
  AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (lateFlag && !lateClr) |=> lateFlag); // R11
  AST_UNDER_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (underrunFlag && !underrunClr) |=> underrunFlag); // R11

endmodule

bind sample_release_gate srel_checker #(.WORD_W(WORD_W)) u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .sampleStrobe  (sampleStrobe),
  .timeLoad      (timeLoad),
  .timeLoadValue (timeLoadValue),
  .timeNow       (timeNow),
  .outValid      (outValid),
  .fifoRead      (fifoRead),
  .fifoEmpty     (fifoEmpty),
  .lateFlag      (lateFlag),
  .lateClr       (lateClr),
  .underrunFlag  (underrunFlag),
  .underrunClr   (underrunClr)
);

// File: tb/sample_release_gate_tb.sv
module sample_release_gate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] fifoData;
  logic        fifoEmpty;
  logic        fifoRead;
  logic        sampleStrobe = 1'b0;
  logic        timeLoad = 1'b0;
  logic [31:0] timeLoadValue = '0;
  logic [31:0] timeNow;
  logic [31:0] outSample;
  logic        outValid;
  logic        lateClr = 1'b0;
  logic        lateFlag;
  logic        underrunClr = 1'b0;
  logic        underrunFlag;

  always #10 clk = ~clk; // 50 MHz

  // bench FIFO model, show-ahead
  logic [31:0] fmem [0:63];
  logic [5:0]  wrP = '0;
  logic [5:0]  rdP = '0;
  assign fifoData  = fmem[rdP];
  assign fifoEmpty = (wrP == rdP);
  always @(posedge clk) if (fifoRead) rdP <= rdP + 1'b1;

  sample_release_gate u_dut (
    .clk(clk), .rstN(rstN), .fifoData(fifoData), .fifoEmpty(fifoEmpty),
    .fifoRead(fifoRead), .sampleStrobe(sampleStrobe), .timeLoad(timeLoad),
    .timeLoadValue(timeLoadValue), .timeNow(timeNow), .outSample(outSample),
    .outValid(outValid), .lateClr(lateClr), .lateFlag(lateFlag),
    .underrunClr(underrunClr), .underrunFlag(underrunFlag)
  );

  int checks = 0;
  int failures = 0;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    fmem[wrP] = w;
    wrP = wrP + 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loadTime(input logic [31:0] v);
    timeLoadValue = v;
    timeLoad = 1'b1;
    @(negedge clk);
    timeLoad = 1'b0;
  endtask

  // one strobe; sample appears the cycle after
  task automatic strobeExpect(input logic [31:0] exp, input string req);
    sampleStrobe = 1'b1;
    @(negedge clk);
    sampleStrobe = 1'b0;
    chk(outValid == 1'b1, "R13", {31'd0, outValid}, 32'd1);
    chk(outSample == exp, req, outSample, exp);
  endtask

  function automatic logic [31:0] smp(input int d, input int n, input int k);
    return 32'hA000_0000 | (d << 16) | (n << 8) | k;
  endfunction

  initial begin
    idle(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1
    chk(outValid == 1'b0, "R1", {31'd0, outValid}, 32'd0);
    chk(lateFlag == 1'b0, "R1", {31'd0, lateFlag}, 32'd0);
    chk(underrunFlag == 1'b0, "R1", {31'd0, underrunFlag}, 32'd0);
    chk(fifoRead == 1'b0, "R1", {31'd0, fifoRead}, 32'd0);
    chk(timeNow == 32'd0, "R1", timeNow, 32'd0);

    // R10 idle strobes give zeros, R2 counting
    strobeExpect(32'd0, "R10");
    strobeExpect(32'd0, "R10");
    chk(timeNow == 32'd2, "R2", timeNow, 32'd2);
    @(negedge clk);
    chk(outValid == 1'b0, "R13", {31'd0, outValid}, 32'd0);
    // R2 load beats strobe
    timeLoadValue = 32'd77; timeLoad = 1'b1; sampleStrobe = 1'b1;
    @(negedge clk);
    timeLoad = 1'b0; sampleStrobe = 1'b0;
    chk(timeNow == 32'd77, "R2", timeNow, 32'd77);

    // sweep: lead d, length n (R4 R5 R6 R3)
    for (int d = 0; d < 4; d++) begin
      for (int n = 1; n < 4; n++) begin
        logic [31:0] t0;
        t0 = 32'd1000 + 32'(d * 100 + n * 10);
        loadTime(t0);
        push(t0 + 32'(d));
        push(32'(n));
        for (int k = 0; k < n; k++) push(smp(d, n, k));
        idle(3);
        chk(32'(wrP - rdP) == 32'(n), "R3", 32'(wrP - rdP), 32'(n));
        for (int j = 0; j < d; j++) strobeExpect(32'd0, "R4");
        chk(32'(wrP - rdP) == 32'(n), "R4", 32'(wrP - rdP), 32'(n));
        for (int k = 0; k < n; k++) strobeExpect(smp(d, n, k), k == 0 ? "R5" : "R6");
        strobeExpect(32'd0, "R6");
        chk(timeNow == t0 + 32'(d + n + 1), "R2", timeNow, t0 + 32'(d + n + 1));
        chk(fifoEmpty == 1'b1, "R6", {31'd0, fifoEmpty}, 32'd1);
      end
    end
    chk(lateFlag == 1'b0, "R8", {31'd0, lateFlag}, 32'd0);

    // R8 plain late packet
    loadTime(32'd200);
    push(32'd195); push(32'd3);
    push(32'h1111_0000); push(32'h1111_0001); push(32'h1111_0002);
    idle(8);
    chk(fifoEmpty == 1'b1, "R8", 32'(wrP - rdP), 32'd0);
    chk(lateFlag == 1'b1, "R8", {31'd0, lateFlag}, 32'd1);
    strobeExpect(32'd0, "R8");
    idle(2);
    chk(lateFlag == 1'b1, "R11", {31'd0, lateFlag}, 32'd1);
    lateClr = 1'b1; @(negedge clk); lateClr = 1'b0;
    chk(lateFlag == 1'b0, "R11", {31'd0, lateFlag}, 32'd0);

    // R8 late across the wrap
    loadTime(32'd5);
    push(32'hFFFF_FFF0); push(32'd1); push(32'h2222_2222);
    idle(6);
    chk(lateFlag == 1'b1, "R8", {31'd0, lateFlag}, 32'd1);
    chk(fifoEmpty == 1'b1, "R8", 32'(wrP - rdP), 32'd0);
    lateClr = 1'b1; @(negedge clk); lateClr = 1'b0;

    // R4 future across the wrap is held
    loadTime(32'hFFFF_FFF0);
    push(32'd5); push(32'd1); push(32'h3333_3333);
    idle(6);
    chk(lateFlag == 1'b0, "R4", {31'd0, lateFlag}, 32'd0);
    chk(32'(wrP - rdP) == 32'd1, "R4", 32'(wrP - rdP), 32'd1);
    loadTime(32'd5);
    strobeExpect(32'h3333_3333, "R5");

    // R7 immediate
    loadTime(32'd50);
    push(32'hFFFF_FFFF); push(32'd2); push(32'h4444_0000); push(32'h4444_0001);
    idle(3);
    strobeExpect(32'h4444_0000, "R7");
    strobeExpect(32'h4444_0001, "R7");
    chk(lateFlag == 1'b0, "R7", {31'd0, lateFlag}, 32'd0);

    // R9 underrun mid-packet
    loadTime(32'd300);
    push(32'd300); push(32'd3); push(32'h5555_0000);
    idle(3);
    strobeExpect(32'h5555_0000, "R9");
    strobeExpect(32'd0, "R9");
    chk(underrunFlag == 1'b1, "R9", {31'd0, underrunFlag}, 32'd1);
    push(32'h5555_0001); push(32'h5555_0002);
    @(negedge clk);
    strobeExpect(32'h5555_0001, "R9");
    strobeExpect(32'h5555_0002, "R9");
    strobeExpect(32'd0, "R9");
    chk(underrunFlag == 1'b1, "R11", {31'd0, underrunFlag}, 32'd1);
    underrunClr = 1'b1; @(negedge clk); underrunClr = 1'b0;
    chk(underrunFlag == 1'b0, "R11", {31'd0, underrunFlag}, 32'd0);

    // R12 zero-length packet skipped
    loadTime(32'd400);
    push(32'd401); push(32'd0);
    push(32'd400); push(32'd1); push(32'h6666_6666);
    idle(6);
    strobeExpect(32'h6666_6666, "R12");
    chk(lateFlag == 1'b0, "R12", {31'd0, lateFlag}, 32'd0);
    chk(fifoEmpty == 1'b1, "R12", 32'(wrP - rdP), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule